// File: doc/BRIEF.md
# Trap Delivery Mode and Handler Vector Selector

When a trap is raised, this block decides where it is delivered and which handler address the core fetches next. It takes the trap type, the current trap depth, the privilege and hyperprivilege status words, the two vector base registers and a small per-trap table of target codes. From these it settles on one of four delivery modes: privileged, hyperprivileged, recovery (RED) or error. It then reports the trap type that is actually taken and the three sequential fetch addresses that begin the handler.

The privilege the core had when the trap arrived comes from two status bits. The target code for that privilege is looked up, and escalation rules are applied in a fixed order. The result is registered one cycle after a trap request is sampled. The block does not touch any saved state, which another unit handles.

Top module: `trap_vector_sel`

## Requirements
- R1: The current level is user when `pstate[2]` is 0, privileged when `pstate[2]` is 1 and `hpstate[2]` is 0, and hyperprivileged when both are 1. The two-bit target code is taken from `tgt_codes[1:0]` for user, `[3:2]` for privileged and `[5:4]` for hyperprivileged.
- R2: Target codes are 0 = privileged, 1 = hyperprivileged, 2 = same-or-higher and 3 = reserved. Code 2 resolves to privileged when the current level is privileged and to hyperprivileged otherwise. Code 3 resolves to hyperprivileged.
- R3: Code 0 taken while the current level is hyperprivileged resolves to hyperprivileged, so a trap never lowers privilege.
- R4: When `hpstate[5]` is 1 or `cur_tl` equals MAX_TL-1 (5), the mode is RED (`out_mode`=2), the trap type passes through unchanged and `out_pc` is 0xFFFFFFFFF00000A0. This rule is checked before every other rule.
- R5: Otherwise, when `cur_tl` is MAX_TL (6) or above, the mode is error (`out_mode`=3), `out_err` is 1, the trap type passes through, and `out_pc`, `out_npc` and `out_nnpc` keep their previous values.
- R6: Otherwise, when the resolved target is privileged and `cur_tl` is above MAX_PTL (2), the trap is delivered hyperprivileged (`out_mode`=1) with trap type 2.
- R7: In hyperprivileged mode, `out_pc` is `htba` with bits [13:0] cleared, ORed with (trap type << 5) masked to 14 bits.
- R8: In privileged mode (`out_mode`=0), `out_pc` is `tba` with bits [14:0] cleared, ORed with bit 14 when `cur_tl`+1 exceeds 1, ORed with (trap type << 5) masked to 14 bits.
- R9: Outside error mode, `out_npc` is `out_pc`+4 and `out_nnpc` is `out_pc`+8.
- R10: A request sampled on `trap_valid` appears on the outputs one clock later with `out_valid` high. In a cycle after no request, `out_valid` is low and every other output holds its value. `out_err` is 1 exactly for error-mode results.
- R11: While reset is asserted, `out_valid`, `out_mode`, `out_tt`, `out_pc`, `out_npc`, `out_nnpc` and `out_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | A trap request is present this cycle |
| trap_type | input | 9 | Raised trap type |
| cur_tl | input | 3 | Current trap depth |
| pstate | input | 13 | Processor status word; bit 2 is the privileged flag |
| hpstate | input | 12 | Hyperprivileged status word; bit 2 is the hyperprivileged flag, bit 5 is the recovery flag |
| tba | input | 64 | Privileged vector base |
| htba | input | 64 | Hyperprivileged vector base |
| tgt_codes | input | 6 | Target code for each current level, two bits per level |
| out_valid | output | 1 | A result is present |
| out_mode | output | 2 | Delivery mode: 0 privileged, 1 hyperprivileged, 2 RED, 3 error |
| out_tt | output | 9 | Trap type actually taken |
| out_pc | output | 64 | Handler address |
| out_npc | output | 64 | Second fetch address |
| out_nnpc | output | 64 | Third fetch address |
| out_err | output | 1 | The result is an error-mode delivery |

## Verification
Directed traps are sent from each current level with each target code. These show whether the level decode and code resolution are right, because a privileged and a hyperprivileged delivery differ both in mode and in vector base. The trap depth is stepped across 0, 1, 2, 3, 5, 6 and 7, with and without the recovery flag. This separates the bit-14 choice, the watchdog redirect boundary at the privileged limit, the RED-before-error ordering and the held addresses in error mode. Idle cycles between traps show that outputs hold. A long run of pseudo-random requests, compared against a requirement-level model, then mixes all rules together.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;
  typedef enum logic [1:0] {
    DM_PRIV  = 2'd0,
    DM_HPRIV = 2'd1,
    DM_RED   = 2'd2,
    DM_ERROR = 2'd3
  } dmode_e;

  typedef enum logic [1:0] {
    LV_USER  = 2'd0,
    LV_PRIV  = 2'd1,
    LV_HPRIV = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    TC_PRIV  = 2'd0,
    TC_HPRIV = 2'd1,
    TC_SAME  = 2'd2,
    TC_RSVD  = 2'd3
  } tcode_e;

  localparam int unsigned CODE_W  = 2;
  localparam int unsigned N_LEVEL = 3;
endpackage

// File: rtl/trap_level_resolve.sv
module trap_level_resolve
  import trapvec_pkg::*;
(
  input  logic                        priv_bit,
  input  logic                        hpriv_bit,
  input  logic [N_LEVEL*CODE_W-1:0]   codes,
  output lvl_e                        cur_lvl,
  output logic                        tgt_hpriv
);
  logic [CODE_W-1:0] code_arr [N_LEVEL];
  tcode_e            sel_code;

  for (genvar g = 0; g < N_LEVEL; g++) begin : g_code
    assign code_arr[g] = codes[g*CODE_W +: CODE_W];
  end

  always_comb begin
    if (!priv_bit)       cur_lvl = LV_USER;
    else if (!hpriv_bit) cur_lvl = LV_PRIV;
    else                 cur_lvl = LV_HPRIV;
  end

  always_comb begin
    sel_code = tcode_e'(code_arr[0]);
    case (cur_lvl)
      LV_PRIV:  sel_code = tcode_e'(code_arr[1]);
      LV_HPRIV: sel_code = tcode_e'(code_arr[2]);
      default:  sel_code = tcode_e'(code_arr[0]);
    endcase
  end

  always_comb begin
    case (sel_code)
      TC_PRIV:  tgt_hpriv = (cur_lvl == LV_HPRIV);
      TC_SAME:  tgt_hpriv = (cur_lvl != LV_PRIV);
      default:  tgt_hpriv = 1'b1;
    endcase
  end
endmodule

// File: rtl/trap_mode_pick.sv
module trap_mode_pick
  import trapvec_pkg::*;
#(
  parameter int unsigned TL_W    = 3,
  parameter int unsigned TT_W    = 9,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2,
  parameter int unsigned WDOG_TT = 2
) (
  input  logic [TL_W-1:0] tl,
  input  logic            red_flag,
  input  logic            tgt_hpriv,
  input  logic [TT_W-1:0] tt_in,
  output dmode_e          mode,
  output logic [TT_W-1:0] tt_eff
);
  localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PLIM = TL_W'(MAX_PTL);

  always_comb begin
    tt_eff = tt_in;
    if (red_flag || tl == TL_RED) begin
      mode = DM_RED;
    end else if (tl >= TL_ERR) begin
      mode = DM_ERROR;
    end else if (!tgt_hpriv && tl > TL_PLIM) begin
      mode   = DM_HPRIV;
      tt_eff = TT_W'(WDOG_TT);
    end else if (tgt_hpriv) begin
      mode = DM_HPRIV;
    end else begin
      mode = DM_PRIV;
    end
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trapvec_pkg::*;
#(
  parameter int unsigned          ADDR_W = 64,
  parameter int unsigned          TT_W   = 9,
  parameter int unsigned          TL_W   = 3,
  parameter logic [ADDR_W-1:0]    RED_PC = 64'hFFFF_FFFF_F000_00A0
) (
  input  dmode_e            mode,
  input  logic [TT_W-1:0]   tt,
  input  logic [TL_W-1:0]   tl,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic [ADDR_W-1:0] nnpc
);
  localparam int unsigned       OFS_BITS = 14;
  localparam int unsigned       ENT_SH   = 5;
  localparam logic [ADDR_W-1:0] OFS_MASK = (ADDR_W'(1) << OFS_BITS) - 1'b1;
  localparam logic [ADDR_W-1:0] PBS_MASK = (ADDR_W'(1) << (OFS_BITS + 1)) - 1'b1;
  localparam logic [ADDR_W-1:0] DEEP_BIT = ADDR_W'(1) << OFS_BITS;

  logic [ADDR_W-1:0] tt_ofs;
  logic              deep;

  assign tt_ofs = (ADDR_W'(tt) << ENT_SH) & OFS_MASK;
  assign deep   = (tl != '0);

  always_comb begin
    case (mode)
      DM_RED:   pc = RED_PC;
      DM_HPRIV: pc = (htba & ~OFS_MASK) | tt_ofs;
      default:  pc = (tba & ~PBS_MASK) | (deep ? DEEP_BIT : '0) | tt_ofs;
    endcase
    npc  = pc + ADDR_W'(4);
    nnpc = pc + ADDR_W'(8);
  end
endmodule

// File: rtl/trap_vector_sel.sv
module trap_vector_sel
  import trapvec_pkg::*;
#(
  parameter int unsigned TT_W    = 9,
  parameter int unsigned TL_W    = 3,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned PS_W    = 13,
  parameter int unsigned HPS_W   = 12,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trap_valid,
  input  logic [TT_W-1:0]           trap_type,
  input  logic [TL_W-1:0]           cur_tl,
  input  logic [PS_W-1:0]           pstate,
  input  logic [HPS_W-1:0]          hpstate,
  input  logic [ADDR_W-1:0]         tba,
  input  logic [ADDR_W-1:0]         htba,
  input  logic [N_LEVEL*CODE_W-1:0] tgt_codes,
  output logic                      out_valid,
  output logic [1:0]                out_mode,
  output logic [TT_W-1:0]           out_tt,
  output logic [ADDR_W-1:0]         out_pc,
  output logic [ADDR_W-1:0]         out_npc,
  output logic [ADDR_W-1:0]         out_nnpc,
  output logic                      out_err
);
  localparam int unsigned PRIV_POS  = 2;
  localparam int unsigned HPRIV_POS = 2;
  localparam int unsigned RED_POS   = 5;

  lvl_e              cur_lvl;
  logic              tgt_hpriv;
  dmode_e            mode_c;
  logic [TT_W-1:0]   tt_c;
  logic [ADDR_W-1:0] pc_c, npc_c, nnpc_c;

  logic              valid_d, err_d;
  dmode_e            mode_d, mode_q;
  logic [TT_W-1:0]   tt_d, tt_q;
  logic [ADDR_W-1:0] pc_d, npc_d, nnpc_d, pc_q, npc_q, nnpc_q;
  logic              valid_q, err_q;

  trap_level_resolve u_lvl (
    .priv_bit  (pstate[PRIV_POS]),
    .hpriv_bit (hpstate[HPRIV_POS]),
    .codes     (tgt_codes),
    .cur_lvl   (cur_lvl),
    .tgt_hpriv (tgt_hpriv)
  );

  trap_mode_pick #(
    .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) u_mode (
    .tl        (cur_tl),
    .red_flag  (hpstate[RED_POS]),
    .tgt_hpriv (tgt_hpriv),
    .tt_in     (trap_type),
    .mode      (mode_c),
    .tt_eff    (tt_c)
  );

  trap_vector_gen #(
    .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W)
  ) u_vec (
    .mode (mode_c),
    .tt   (tt_c),
    .tl   (cur_tl),
    .tba  (tba),
    .htba (htba),
    .pc   (pc_c),
    .npc  (npc_c),
    .nnpc (nnpc_c)
  );

  // next state; payload advances only on a request
  always_comb begin
    valid_d = trap_valid;
    mode_d  = mode_q;
    tt_d    = tt_q;
    pc_d    = pc_q;
    npc_d   = npc_q;
    nnpc_d  = nnpc_q;
    err_d   = err_q;
    if (trap_valid) begin
      mode_d = mode_c;
      tt_d   = tt_c;
      err_d  = (mode_c == DM_ERROR);
      if (mode_c != DM_ERROR) begin
        pc_d   = pc_c;
        npc_d  = npc_c;
        nnpc_d = nnpc_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= DM_PRIV;
      tt_q    <= '0;
      pc_q    <= '0;
      npc_q   <= '0;
      nnpc_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mode_q  <= mode_d;
      tt_q    <= tt_d;
      pc_q    <= pc_d;
      npc_q   <= npc_d;
      nnpc_q  <= nnpc_d;
      err_q   <= err_d;
    end
  end

  assign out_valid = valid_q;
  assign out_mode  = mode_q;
  assign out_tt    = tt_q;
  assign out_pc    = pc_q;
  assign out_npc   = npc_q;
  assign out_nnpc  = nnpc_q;
  assign out_err   = err_q;
endmodule

// File: rtl/trap_vector_sel_chk.sv
module trap_vector_sel_chk #(
  parameter int unsigned TT_W    = 9,
  parameter int unsigned TL_W    = 3,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned HPS_W   = 12,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_valid,
  input logic [TL_W-1:0]   cur_tl,
  input logic [HPS_W-1:0]  hpstate,
  input logic              out_valid,
  input logic [1:0]        out_mode,
  input logic [TT_W-1:0]   out_tt,
  input logic [ADDR_W-1:0] out_pc,
  input logic [ADDR_W-1:0] out_npc,
  input logic [ADDR_W-1:0] out_nnpc,
  input logic              out_err
);
  localparam logic [TL_W-1:0]   TL_RED = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0]   TL_LIM = TL_W'(MAX_PTL);
  localparam logic [ADDR_W-1:0] RED_A  = 64'hFFFF_FFFF_F000_00A0;

  AST_RED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && (hpstate[5] || cur_tl == TL_RED) |=> out_valid && out_mode == 2'd2) // R4
    else $error("AST_RED_FIRST");

  AST_RED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == 2'd2 |-> out_pc == RED_A) // R4
    else $error("AST_RED_ADDR");

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == 2'd3 |-> $stable(out_pc) && $stable(out_npc) && $stable(out_nnpc)) // R5
    else $error("AST_ERR_HOLD");

  AST_PRIV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && cur_tl > TL_LIM |=> out_mode != 2'd0) // R6
    else $error("AST_PRIV_LIMIT");

  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode != 2'd3 |-> out_npc == out_pc + 4 && out_nnpc == out_pc + 8) // R9
    else $error("AST_SEQ_ADDR");

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> out_valid) // R10
    else $error("AST_VALID_LAT");

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !out_valid && $stable(out_pc) && $stable(out_tt) && $stable(out_mode)) // R10
    else $error("AST_IDLE_HOLD");

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_err == (out_mode == 2'd3)) // R10
    else $error("AST_ERR_FLAG");
endmodule

bind trap_vector_sel trap_vector_sel_chk #(
  .TT_W(TT_W), .TL_W(TL_W), .ADDR_W(ADDR_W), .HPS_W(HPS_W),
  .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .cur_tl     (cur_tl),
  .hpstate    (hpstate),
  .out_valid  (out_valid),
  .out_mode   (out_mode),
  .out_tt     (out_tt),
  .out_pc     (out_pc),
  .out_npc    (out_npc),
  .out_nnpc   (out_nnpc),
  .out_err    (out_err)
);

// File: tb/tb_trap_vector_sel.sv
`timescale 1ns/1ps
module tb_trap_vector_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_valid;
  logic [8:0]  trap_type;
  logic [2:0]  cur_tl;
  logic [12:0] pstate;
  logic [11:0] hpstate;
  logic [63:0] tba, htba;
  logic [5:0]  tgt_codes;
  logic        out_valid, out_err;
  logic [1:0]  out_mode;
  logic [8:0]  out_tt;
  logic [63:0] out_pc, out_npc, out_nnpc;

  always #2.5 clk = ~clk;

  trap_vector_sel dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_type(trap_type),
    .cur_tl(cur_tl), .pstate(pstate), .hpstate(hpstate), .tba(tba), .htba(htba),
    .tgt_codes(tgt_codes), .out_valid(out_valid), .out_mode(out_mode),
    .out_tt(out_tt), .out_pc(out_pc), .out_npc(out_npc), .out_nnpc(out_nnpc),
    .out_err(out_err)
  );

  typedef struct {
    logic        v;
    logic [1:0]  m;
    logic [8:0]  tt;
    logic [63:0] pc, npc, nnpc;
    logic        e;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [1:0]  l_m  = 2'd0;
  logic [8:0]  l_tt = '0;
  logic [63:0] l_pc = '0, l_npc = '0, l_nnpc = '0;
  logic        l_e  = 1'b0;

  localparam logic [63:0] RED_A = 64'hFFFF_FFFF_F000_00A0;

  task automatic apply(input logic v, input logic [8:0] tt, input logic [2:0] tl,
                       input logic p, input logic h, input logic red,
                       input logic [5:0] codes, input logic [63:0] tb_i,
                       input logic [63:0] htb_i, input string tag);
    exp_t e;
    int   lvl;
    logic [1:0] c;
    logic hyp;
    @(negedge clk);
    trap_valid = v; trap_type = tt; cur_tl = tl;
    pstate = 13'h1A53; pstate[2] = p;
    hpstate = 12'h8C2; hpstate[2] = h; hpstate[5] = red;
    tgt_codes = codes; tba = tb_i; htba = htb_i;
    lvl = !p ? 0 : (!h ? 1 : 2);
    c   = codes[lvl*2 +: 2];
    hyp = (c == 2'd1) || (c == 2'd3) || (c == 2'd2 && lvl != 1) || (c == 2'd0 && lvl == 2);
    if (v) begin
      l_tt = tt;
      if (red || tl == 3'd5) begin
        l_m = 2'd2; l_pc = RED_A;
      end else if (tl >= 3'd6) begin
        l_m = 2'd3;
      end else if (!hyp && tl > 3'd2) begin
        l_m = 2'd1; l_tt = 9'd2;
        l_pc = (htb_i & ~64'h3FFF) | ((64'(l_tt) << 5) & 64'h3FFF);
      end else if (hyp) begin
        l_m = 2'd1;
        l_pc = (htb_i & ~64'h3FFF) | ((64'(tt) << 5) & 64'h3FFF);
      end else begin
        l_m = 2'd0;
        l_pc = (tb_i & ~64'h7FFF) | ((tl + 4'd1 > 4'd1) ? 64'h4000 : 64'h0)
               | ((64'(tt) << 5) & 64'h3FFF);
      end
      if (l_m != 2'd3) begin
        l_npc = l_pc + 64'd4; l_nnpc = l_pc + 64'd8;
      end
      l_e = (l_m == 2'd3);
    end
    e.v = v; e.m = l_m; e.tt = l_tt; e.pc = l_pc; e.npc = l_npc; e.nnpc = l_nnpc;
    e.e = l_e; e.tag = tag;
    @(posedge clk);
    sb.push_back(e);
  endtask

  // monitor: pops one expected item per clock and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (out_valid !== e.v || out_mode !== e.m || out_tt !== e.tt || out_pc !== e.pc ||
            out_npc !== e.npc || out_nnpc !== e.nnpc || out_err !== e.e) begin
          fails++;
          $display("FAIL %s: got v=%0b m=%0d tt=%h pc=%h npc=%h nnpc=%h err=%0b exp v=%0b m=%0d tt=%h pc=%h npc=%h nnpc=%h err=%0b",
                   e.tag, out_valid, out_mode, out_tt, out_pc, out_npc, out_nnpc, out_err,
                   e.v, e.m, e.tt, e.pc, e.npc, e.nnpc, e.e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [63:0] TB0 = 64'h0000_0012_3456_F000;
  localparam logic [63:0] HB0 = 64'h0000_00AB_CDEF_7FFF;

  initial begin
    rst_n = 1'b0; trap_valid = 1'b0; trap_type = '0; cur_tl = '0;
    pstate = '0; hpstate = '0; tba = '0; htba = '0; tgt_codes = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_mode !== 2'd0 || out_tt !== '0 || out_pc !== '0 ||
        out_npc !== '0 || out_nnpc !== '0 || out_err !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: got v=%0b m=%0d pc=%h exp all zero", out_valid, out_mode, out_pc);
    end
    rst_n = 1'b1;
    // R1 R8: user, code P, tl 0 -> privileged vector without bit 14
    apply(1, 9'h034, 3'd0, 0, 0, 0, 6'b01_01_00, TB0, HB0, "R1_R8 user P tl0");
    // R8: privileged, tl 1 -> bit 14 set
    apply(1, 9'h021, 3'd1, 1, 0, 0, 6'b01_00_01, TB0, HB0, "R8 priv tl1 bit14");
    // R7: hyper current, code H
    apply(1, 9'h1FF, 3'd2, 1, 1, 0, 6'b01_00_00, TB0, HB0, "R7 hyper vector");
    // R2: SH from user -> hyper; SH from priv -> priv
    apply(1, 9'h041, 3'd0, 0, 0, 0, 6'b00_00_10, TB0, HB0, "R2 SH user");
    apply(1, 9'h041, 3'd1, 1, 0, 0, 6'b00_10_00, TB0, HB0, "R2 SH priv");
    // R2: reserved code -> hyper
    apply(1, 9'h010, 3'd0, 0, 0, 0, 6'b00_00_11, TB0, HB0, "R2 rsvd code");
    // R3: code P while hyper -> hyper
    apply(1, 9'h011, 3'd1, 1, 1, 0, 6'b00_01_01, TB0, HB0, "R3 no downgrade");
    // R10: idle cycle holds
    apply(0, 9'h0AA, 3'd0, 0, 0, 0, 6'b00_00_00, 64'hFFFF, 64'hFFFF, "R10 idle hold");
    // R6: boundary tl=2 stays privileged, tl=3 redirects
    apply(1, 9'h100, 3'd2, 1, 0, 0, 6'b00_00_00, TB0, HB0, "R6 tl at limit");
    apply(1, 9'h100, 3'd3, 1, 0, 0, 6'b00_00_00, TB0, HB0, "R6 watchdog redirect");
    apply(1, 9'h100, 3'd4, 0, 0, 0, 6'b00_00_10, TB0, HB0, "R6 SH user tl4 no redirect");
    // R4: RED by depth and by flag
    apply(1, 9'h024, 3'd5, 1, 0, 0, 6'b00_00_00, TB0, HB0, "R4 red depth");
    apply(1, 9'h029, 3'd0, 1, 1, 1, 6'b01_01_01, TB0, HB0, "R4 red flag");
    // R9: prime a known pc before error
    apply(1, 9'h068, 3'd1, 1, 1, 0, 6'b01_01_01, TB0, HB0, "R9 prime");
    // R5: error at 6 and 7, pcs held
    apply(1, 9'h030, 3'd6, 1, 0, 0, 6'b00_00_00, TB0, HB0, "R5 error tl6");
    apply(1, 9'h031, 3'd7, 0, 0, 0, 6'b01_01_01, TB0, HB0, "R5 error tl7");
    apply(0, 9'h000, 3'd0, 0, 0, 0, 6'b00_00_00, TB0, HB0, "R10 idle after error");
    // R4: red flag beats error depth
    apply(1, 9'h005, 3'd6, 1, 0, 1, 6'b00_00_00, TB0, HB0, "R4 red over error");
    apply(1, 9'h00A, 3'd0, 0, 0, 0, 6'b00_00_00, TB0, HB0, "R8 after red");
    // mixed pseudo-random traffic (R1..R10)
    for (int i = 0; i < 400; i++) begin
      apply(($urandom % 5) != 0, 9'($urandom), 3'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 6) == 0, 6'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, "R1-mix random");
    end
    apply(0, 9'h0, 3'd0, 0, 0, 0, 6'b0, TB0, HB0, "R10 final idle");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule